// File: doc/BRIEF.md
# Interrupt Flag and Request Controller

This block combines three interrupt sources of a timekeeping core: a periodic tick, an alarm match and the end of an update pass. Each source has a sticky flag that is set by a one-cycle event pulse, whatever its enable says. Software enables the sources through a control byte. The block drives an open-drain, active-low request line. It does this by asserting `irq_pull` to pull the pin low, and releases the pin when `irq_pull` is 0.

The flag byte clears itself when it is read. `rd_flags` is held high for the length of a bus read. The byte presented during that window is frozen. Events that arrive inside the window are parked and are posted only when the read completes, so none is lost. The update source also observes the freeze bit `set_hold`: while that bit is 1, an update flag still latches but raises no request. All ports are plain control and status signals, with no stream handshake and therefore no back-pressure.

Top module: `irq_flag_ctrl`

## Requirements
- R1: While `rst_n` is low, every flag and every enable is cleared, `flag_q` and `ctl_q` read 0x00, and `irq_pull` is 0.
- R2: An event pulse sets its flag at the next clock edge even when its enable is 0. In `flag_q`, the periodic flag is bit 6, the alarm flag is bit 5 and the update flag is bit 4.
- R3: `irq_pull` and `flag_q` bit 7 are 1 exactly while some source has both its flag and its enable set. The enables are `ctl_q` bit 6 (periodic), bit 5 (alarm) and bit 4 (update).
- R4: If a flag is already set, writing its enable to 1 raises `irq_pull` in the cycle right after the write edge.
- R5: When `rd_flags` falls, the clock edge that samples it low clears all flags and bit 7. If nothing was parked, `flag_q` reads 0x00 and `irq_pull` is 0 after that edge.
- R6: While `rd_flags` stays high, `flag_q` keeps the value it showed in the first cycle of the read. Events during the read do not change it, and they appear as flags after the read ends.
- R7: The update source raises `irq_pull` only while `set_hold` is 0. Its flag still sets when `set_hold` is 1.
- R8: Bits 3 to 0 of `flag_q` always read 0.
- R9: An event parked during a read, and an event arriving on the clock edge that ends the read, both survive the clear.
- R10: A control write (`ctl_we`) stores bits 6 to 3 of `ctl_wdata`, where bit 3 is the square-wave enable. The other bits of `ctl_q` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_periodic | input | 1 | One-cycle periodic tick event |
| evt_alarm | input | 1 | One-cycle alarm match event |
| evt_update | input | 1 | One-cycle update-ended event |
| set_hold | input | 1 | Freeze bit; masks the update request |
| rd_flags | input | 1 | High for the duration of a flag byte read |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_q | output | 8 | Stored enables (bits 6..3), rest 0 |
| flag_q | output | 8 | Flag byte: bit 7 summary, bits 6..4 flags |
| irq_pull | output | 1 | 1 pulls the open-drain request pin low |

## Verification
The hardest case to reach from the ports is an event that lands inside a read window, or on the exact edge where the window closes. This is where the clear and the parked event compete. The random stimulus opens reads of one to four cycles while all three event lines fire often, so collisions recur many times. Directed cases also place an alarm event mid-read and a periodic event on the closing edge, and then check that both flags survive.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC     = 3;
  localparam int SRC_UPD  = 0;
  localparam int SRC_ALM  = 1;
  localparam int SRC_PER  = 2;
  localparam int DW       = 8;
  localparam int FLAG_LSB = 4;
  localparam int SUM_BIT  = 7;
  localparam int EN_LSB   = 3;
  localparam int EN_W     = NSRC + 1;
endpackage

// File: rtl/irqc_enable_reg.sv
module irqc_enable_reg #(
  parameter int DW     = 8,
  parameter int EN_LSB = 3,
  parameter int EN_W   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [DW-1:0]   wdata,
  output logic [EN_W-1:0] en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en_q <= '0;
    else if (we) en_q <= wdata[EN_LSB +: EN_W];
  end
endmodule

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd,
  input  logic         rd_end,
  input  logic [N-1:0] evt,
  output logic [N-1:0] flags,
  output logic [N-1:0] held
);
  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags[i] <= 1'b0;
        held[i]  <= 1'b0;
      end else if (rd) begin
        held[i]  <= held[i] | evt[i];
      end else if (rd_end) begin
        flags[i] <= held[i] | evt[i];
        held[i]  <= 1'b0;
      end else begin
        flags[i] <= flags[i] | evt[i];
      end
    end
  end
endmodule

// File: rtl/irqc_irq_combine.sv
module irqc_irq_combine #(
  parameter int N       = 3,
  parameter int UPD_IDX = 0
) (
  input  logic [N-1:0] flags,
  input  logic [N-1:0] en,
  input  logic         set_hold,
  output logic         irq_any
);
  logic [N-1:0] act;
  for (genvar i = 0; i < N; i++) begin : g_act
    if (i == UPD_IDX) begin : g_upd
      assign act[i] = flags[i] & en[i] & ~set_hold;
    end else begin : g_plain
      assign act[i] = flags[i] & en[i];
    end
  end
  assign irq_any = |act;
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irqc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_periodic,
  input  logic       evt_alarm,
  input  logic       evt_update,
  input  logic       set_hold,
  input  logic       rd_flags,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_q,
  output logic [7:0] flag_q,
  output logic       irq_pull
);
  logic [NSRC-1:0] evt_vec;
  logic [NSRC-1:0] flag_vec;
  logic [NSRC-1:0] held_vec;
  logic [EN_W-1:0] en_q;
  logic            rd_q;
  logic            rd_end;
  logic            irq_any;
  logic [DW-1:0]   live;
  logic [DW-1:0]   snap;

  always_comb begin
    evt_vec          = '0;
    evt_vec[SRC_PER] = evt_periodic;
    evt_vec[SRC_ALM] = evt_alarm;
    evt_vec[SRC_UPD] = evt_update;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd_flags;
  end
  assign rd_end = rd_q & ~rd_flags;

  irqc_enable_reg #(.DW(DW), .EN_LSB(EN_LSB), .EN_W(EN_W)) u_en (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata), .en_q(en_q)
  );

  irqc_flag_bank #(.N(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .rd(rd_flags), .rd_end(rd_end),
    .evt(evt_vec), .flags(flag_vec), .held(held_vec)
  );

  irqc_irq_combine #(.N(NSRC), .UPD_IDX(SRC_UPD)) u_comb (
    .flags(flag_vec), .en(en_q[EN_W-1:1]), .set_hold(set_hold), .irq_any(irq_any)
  );

  always_comb begin
    live                        = '0;
    live[SUM_BIT]               = irq_any;
    live[FLAG_LSB +: NSRC]      = flag_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  snap <= '0;
    else if (rd_flags && !rd_q)  snap <= live;
  end

  assign flag_q   = rd_q ? snap : live;
  assign irq_pull = irq_any;

  always_comb begin
    ctl_q                    = '0;
    ctl_q[EN_LSB +: EN_W]    = en_q;
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rd,
  input logic [2:0] evt,
  input logic [2:0] held,
  input logic [7:0] flag_q,
  input logic       irq_pull
);
  always @(posedge clk) begin
    if (!rst_n) p_reset_release_r1: assert (!irq_pull);
  end

  p_event_sets_per_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[2] && !rd) |=> flag_q[6]);

  p_irq_needs_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pull |-> (|flag_q[6:4]));

  p_clear_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd) && !rd && held == 3'b000 && evt == 3'b000) |=> (flag_q == 8'h00));

  p_read_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && $past(rd)) |-> $stable(flag_q));

  p_low_nibble_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q[3:0] == 4'h0);
endmodule

bind irq_flag_ctrl irqc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rd(rd_flags), .evt(evt_vec),
  .held(held_vec), .flag_q(flag_q), .irq_pull(irq_pull)
);

// File: tb/sim_irq_flag_ctrl.sv
`timescale 1ns/1ps
module sim_irq_flag_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_periodic = 0, evt_alarm = 0, evt_update = 0, set_hold = 0;
  logic rd_flags = 0, ctl_we = 0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_q, flag_q;
  logic irq_pull;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  irq_flag_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .evt_periodic(evt_periodic), .evt_alarm(evt_alarm),
    .evt_update(evt_update), .set_hold(set_hold), .rd_flags(rd_flags),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q), .flag_q(flag_q),
    .irq_pull(irq_pull)
  );

  // Model state: m_f[2]=periodic, [1]=alarm, [0]=update; m_en[3]=PIE..[0]=SQWE
  logic [2:0] m_f = 0, m_h = 0;
  logic [3:0] m_en = 0;
  logic       m_rdq = 0;
  logic [7:0] m_snap = 0;

  function automatic logic exp_irq();
    return (m_f[2] & m_en[3]) | (m_f[1] & m_en[2]) | (m_f[0] & m_en[1] & ~set_hold);
  endfunction
  function automatic logic [7:0] exp_live();
    return {exp_irq(), m_f, 4'h0};
  endfunction
  function automatic logic [7:0] exp_flag();
    return m_rdq ? m_snap : exp_live();
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic [2:0] e;
    e = {evt_periodic, evt_alarm, evt_update};
    if (rd_flags && !m_rdq) m_snap = exp_live();
    if (rd_flags) m_h = m_h | e;
    else if (m_rdq) begin m_f = m_h | e; m_h = 0; end
    else m_f = m_f | e;
    if (ctl_we) m_en = ctl_wdata[6:3];
    m_rdq = rd_flags;
  endtask

  // Compare outputs against the model, then advance one clock.
  task automatic cyc(input string tag);
    #1;
    chk({tag, " flag"}, flag_q, exp_flag());
    chk({tag, " irq"}, {7'd0, irq_pull}, {7'd0, exp_irq()});
    chk("R8 low nibble", {4'h0, flag_q[3:0]}, 8'h00);
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle();
    evt_periodic = 0; evt_alarm = 0; evt_update = 0; ctl_we = 0; rd_flags = 0;
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int rd_left;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 flag", flag_q, 8'h00);
    chk("R1 ctl", ctl_q, 8'h00);
    chk("R1 irq", {7'd0, irq_pull}, 8'h00);
    rst_n = 1;
    cyc("R1");

    // R10: only bits 6..3 stored
    ctl_we = 1; ctl_wdata = 8'hFF; cyc("R10"); idle();
    chk("R10 ctl", ctl_q, 8'h78);
    ctl_we = 1; ctl_wdata = 8'h00; cyc("R10"); idle();

    // R2: flag without enable
    evt_periodic = 1; cyc("R2"); idle();
    chk("R2 flag", flag_q, 8'h40);
    chk("R2 irq", {7'd0, irq_pull}, 8'h00);

    // R4: pending flag then enable write
    ctl_we = 1; ctl_wdata = 8'h40; cyc("R4"); idle();
    chk("R4 irq", {7'd0, irq_pull}, 8'h01);
    chk("R4 flag", flag_q, 8'hC0);

    // R6 + R5: read with mid-read alarm event
    rd_flags = 1; cyc("R6");
    evt_alarm = 1; cyc("R6"); evt_alarm = 0;
    chk("R6 frozen", flag_q, 8'hC0);
    cyc("R6");
    chk("R6 frozen", flag_q, 8'hC0);
    rd_flags = 0; cyc("R6");
    chk("R6 parked alarm", flag_q, 8'h20);
    // read again with nothing arriving -> cleared
    rd_flags = 1; cyc("R5"); cyc("R5");
    rd_flags = 0; cyc("R5");
    chk("R5 cleared", flag_q, 8'h00);
    chk("R5 irq", {7'd0, irq_pull}, 8'h00);

    // R9: parked alarm plus periodic on the closing edge
    rd_flags = 1; cyc("R9");
    evt_alarm = 1; cyc("R9"); evt_alarm = 0;
    rd_flags = 0; evt_periodic = 1; cyc("R9"); idle();
    chk("R9 both survive", flag_q, 8'hE0);
    rd_flags = 1; cyc("R9"); rd_flags = 0; cyc("R9");

    // R7: update masked by set_hold
    ctl_we = 1; ctl_wdata = 8'h10; cyc("R7"); idle();
    set_hold = 1; evt_update = 1; cyc("R7"); idle();
    chk("R7 flag held", flag_q, 8'h10);
    chk("R7 irq masked", {7'd0, irq_pull}, 8'h00);
    set_hold = 0; #1;
    chk("R7 irq open", {7'd0, irq_pull}, 8'h01);
    chk("R7 summary", flag_q, 8'h90);
    cyc("R7");

    // Random mix
    rd_left = 0;
    for (int n = 0; n < 3000; n++) begin
      evt_periodic = ($urandom % 6) == 0;
      evt_alarm    = ($urandom % 6) == 0;
      evt_update   = ($urandom % 6) == 0;
      if (($urandom % 16) == 0) set_hold = ~set_hold;
      ctl_we = ($urandom % 10) == 0;
      ctl_wdata = 8'($urandom);
      if (rd_left > 0) rd_left--;
      else if (($urandom % 5) == 0) rd_left = 1 + ($urandom % 4);
      rd_flags = rd_left > 0;
      cyc(m_rdq ? "R6 rand" : "R3 rand");
    end
    idle();
    cyc("R3");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule